// File: doc/BRIEF.md
# I2C Master SCL Low-Time Watchdog

This block sits beside an I2C master engine and watches the synchronized clock line while a transfer is in progress. A slave that stretches SCL holds the line low. The block counts how many system clocks the line has stayed low while the bus is busy. When that count reaches a programmable limit, the block sends a one-cycle abort request to the master engine, which then ends the transfer with a STOP condition. At the same moment it sets a sticky timeout status bit. That bit drives an interrupt output through a mask.

Software programs an 8-bit limit value. Each unit of the limit stands for 16 system clocks. A limit of zero switches the watchdog off completely. A limit of one is reserved: it gives a 16-clock window, which is shorter than a normal byte, so it cuts transfers off early. The abort is issued whether or not the interrupt is masked. The mask controls only the interrupt pin.

Top module: `sclHoldGuard`

## Requirements
- R1: After reset, the limit readback is 0, the raw status is 0, the masked interrupt is 0 and the abort request is 0.
- R2: While the limit is 0, SCL may stay low for any length of time on a busy bus and the block raises neither an abort nor the raw status.
- R3: With limit N of 2 or more, let SCL be low and the bus busy from edge k onward. The abort request is then high for exactly the one clock that follows edge k+16N+1.
- R4: The abort request is a one-cycle pulse. While SCL stays low on a busy bus after a timeout, no second request follows. A new one can come only after SCL has been high or the bus has gone idle.
- R5: The abort request and the raw status are raised whatever the mask is. The interrupt output equals the raw status ANDed with the mask input.
- R6: The raw status stays set until a clear strobe. If a timeout and a clear happen on the same edge, the status ends up set.
- R7: Any clock in which SCL is high resets the low-time measurement to zero.
- R8: Clocks in which the bus is idle do not count, and an idle clock resets the measurement to zero.
- R9: A write to the limit register restarts the measurement. Counting begins again on the edge after the write edge, and the new limit applies.
- R10: The reserved limit 1 works as a 16-clock window, so the abort comes 17 edges after SCL goes low.
- R11: The limit readback returns the value written last.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sclSync | input | 1 | SCL level, already synchronized to clk |
| busBusy | input | 1 | High while a transfer owns the bus |
| limitWrEn | input | 1 | Write strobe for the limit register |
| limitWrData | input | LIMIT_W | Limit value to write, in units of 16 clocks |
| irqMask | input | 1 | Interrupt enable (1 = interrupt passes) |
| statusClr | input | 1 | Write-one-to-clear strobe for the raw status |
| limitRd | output | LIMIT_W | Current limit register value |
| rawFlag | output | 1 | Sticky timeout status |
| maskedIrq | output | 1 | Timeout interrupt after the mask |
| abortReq | output | 1 | One-cycle request to the master to abort with a STOP |

## Verification
The bench predicts the exact cycle of every abort and checks it. A counter off by one edge, or one that ignores the prescale, shows up as a mismatch in the scoreboard. The bench holds SCL low well past the limit. A design without the re-arm guard would pulse again. A design that counts across a brief high level or across an idle gap would fire early. The bench runs a timeout with the mask off to catch a design that lets the mask block the abort. It clears the status on the timeout edge to catch a design where the clear wins. It uses limits 0 and 1 to catch a disabled watchdog that still fires and a reserved value that is not treated as a short window.

// File: rtl/sclHoldPkg.sv
package sclHoldPkg;
  typedef struct packed {
    logic cntClear;
    logic cntInc;
  } holdStrobe_t;
endpackage

// File: rtl/sclHoldDatapath.sv
module sclHoldDatapath
  import sclHoldPkg::*;
#(
  parameter int LIMIT_W       = 8,
  parameter int PRESCALE_LOG2 = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               limitWrEn,
  input  logic [LIMIT_W-1:0] limitWrData,
  input  holdStrobe_t        strobe,
  output logic [LIMIT_W-1:0] limitQ,
  output logic               enabled,
  output logic               reachedLimit
);
  localparam int CNT_W = LIMIT_W + PRESCALE_LOG2 + 1;

  logic [CNT_W-1:0] lowCnt;
  logic [CNT_W-1:0] periodClks;

  // limit register, in units of 2**PRESCALE_LOG2 clocks
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          limitQ <= '0;
    else if (limitWrEn) limitQ <= limitWrData;
  end

  assign periodClks   = CNT_W'({limitQ, {PRESCALE_LOG2{1'b0}}});
  assign enabled      = (limitQ != '0);
  assign reachedLimit = (lowCnt == periodClks);

  // low-time counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                lowCnt <= '0;
    else if (strobe.cntClear) lowCnt <= '0;
    else if (strobe.cntInc)   lowCnt <= lowCnt + 1'b1;
  end

  // R3: the counter never runs past one step beyond the window
  a_r3_count_bounded: assert property (@(posedge clk) disable iff (!rstN)
    lowCnt <= periodClks + 1'b1);

  // R9: a limit write leaves the counter at zero
  a_r9_write_restarts: assert property (@(posedge clk) disable iff (!rstN)
    limitWrEn |=> (lowCnt == '0));
endmodule

// File: rtl/sclHoldCtrl.sv
module sclHoldCtrl
  import sclHoldPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        sclSync,
  input  logic        busBusy,
  input  logic        limitWrEn,
  input  logic        irqMask,
  input  logic        statusClr,
  input  logic        enabled,
  input  logic        reachedLimit,
  output holdStrobe_t strobe,
  output logic        abortReq,
  output logic        rawFlag,
  output logic        maskedIrq
);
  logic lowActive;
  logic fired;
  logic hit;

  assign lowActive = busBusy && !sclSync;
  assign hit       = lowActive && enabled && !fired && reachedLimit && !limitWrEn;

  always_comb begin
    strobe          = '0;
    strobe.cntClear = !lowActive || limitWrEn;
    strobe.cntInc   = lowActive && enabled && !fired;
  end

  // re-arm guard: one request per low period
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          fired <= 1'b0;
    else if (!lowActive) fired <= 1'b0;
    else if (hit)        fired <= 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) abortReq <= 1'b0;
    else       abortReq <= hit;
  end

  // sticky status, set wins over clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          rawFlag <= 1'b0;
    else if (hit)       rawFlag <= 1'b1;
    else if (statusClr) rawFlag <= 1'b0;
  end

  assign maskedIrq = rawFlag && irqMask;

  // R4: request lasts one cycle
  a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    abortReq |=> !abortReq);

  // R2: no request unless the watchdog was enabled
  a_r2_disabled_quiet: assert property (@(posedge clk) disable iff (!rstN)
    abortReq |-> $past(enabled));

  // R5: a request always comes with the raw status
  a_r5_abort_sets_raw: assert property (@(posedge clk) disable iff (!rstN)
    abortReq |-> rawFlag);

  // R6: status holds without a clear
  a_r6_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (rawFlag && !statusClr) |=> rawFlag);
endmodule

// File: rtl/sclHoldGuard.sv
module sclHoldGuard
  import sclHoldPkg::*;
#(
  parameter int LIMIT_W       = 8,
  parameter int PRESCALE_LOG2 = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sclSync,
  input  logic               busBusy,
  input  logic               limitWrEn,
  input  logic [LIMIT_W-1:0] limitWrData,
  input  logic               irqMask,
  input  logic               statusClr,
  output logic [LIMIT_W-1:0] limitRd,
  output logic               rawFlag,
  output logic               maskedIrq,
  output logic               abortReq
);
  holdStrobe_t strobe;
  logic        enabled;
  logic        reachedLimit;

  sclHoldDatapath #(.LIMIT_W(LIMIT_W), .PRESCALE_LOG2(PRESCALE_LOG2)) uPath (
    .clk(clk), .rstN(rstN), .limitWrEn(limitWrEn), .limitWrData(limitWrData),
    .strobe(strobe), .limitQ(limitRd), .enabled(enabled), .reachedLimit(reachedLimit)
  );

  sclHoldCtrl uCtrl (
    .clk(clk), .rstN(rstN), .sclSync(sclSync), .busBusy(busBusy),
    .limitWrEn(limitWrEn), .irqMask(irqMask), .statusClr(statusClr),
    .enabled(enabled), .reachedLimit(reachedLimit), .strobe(strobe),
    .abortReq(abortReq), .rawFlag(rawFlag), .maskedIrq(maskedIrq)
  );
endmodule

// File: tb/tb_sclHoldGuard.sv
`timescale 1ns/1ps
module tb_sclHoldGuard;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       sclSync = 1'b1;
  logic       busBusy = 1'b0;
  logic       limitWrEn = 1'b0;
  logic [7:0] limitWrData = '0;
  logic       irqMask = 1'b0;
  logic       statusClr = 1'b0;
  logic [7:0] limitRd;
  logic       rawFlag, maskedIrq, abortReq;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int curLimit = 0;
  bit doneFlag = 0;
  int expQ[$];

  sclHoldGuard dut (
    .clk(clk), .rstN(rstN), .sclSync(sclSync), .busBusy(busBusy),
    .limitWrEn(limitWrEn), .limitWrData(limitWrData), .irqMask(irqMask),
    .statusClr(statusClr), .limitRd(limitRd), .rawFlag(rawFlag),
    .maskedIrq(maskedIrq), .abortReq(abortReq)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: every abort must match the head of the expected queue
  always @(negedge clk) begin
    if (rstN && abortReq) begin
      if (expQ.size() == 0) check(1'b0, "R2/R4 unexpected abort at cycle", cyc, -1);
      else begin
        int e;
        e = expQ.pop_front();
        check(cyc == e, "R3 abort cycle", cyc, e);
      end
    end
  end

  task automatic finishRun();
    if (!doneFlag) begin
      doneFlag = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog expired", cyc, 0);
    finishRun();
  end

  task automatic waitCycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic writeLimit(input int v);
    @(negedge clk);
    limitWrEn = 1'b1; limitWrData = 8'(v);
    @(negedge clk);
    limitWrEn = 1'b0;
    curLimit = v;
  endtask

  // drive SCL low at a negedge and push the predicted abort cycle (R3)
  task automatic lowStart(output int e);
    @(negedge clk);
    sclSync = 1'b0;
    e = cyc + curLimit * 16 + 1;
    if (curLimit != 0 && busBusy) expQ.push_back(e);
  endtask

  task automatic sclHigh();
    @(negedge clk);
    sclSync = 1'b1;
  endtask

  initial begin
    int e;
    waitCycles(3);
    rstN = 1'b1;
    waitCycles(1);
    // R1
    check(limitRd == 0, "R1 limit reset", limitRd, 0);
    check(rawFlag == 0, "R1 raw reset", rawFlag, 0);
    check(maskedIrq == 0, "R1 irq reset", maskedIrq, 0);
    check(abortReq == 0, "R1 abort reset", abortReq, 0);

    // R2: disabled, SCL held low for a long time
    busBusy = 1'b1;
    lowStart(e);
    waitCycles(400);
    check(rawFlag == 0, "R2 raw stays clear", rawFlag, 0);
    sclHigh();

    // R11 readback
    writeLimit(3);
    check(limitRd == 3, "R11 limit readback", limitRd, 3);

    // R3 + R5 (mask off, abort still issued)
    lowStart(e);
    waitCycles(60);
    check(rawFlag == 1, "R5 raw set while masked", rawFlag, 1);
    check(maskedIrq == 0, "R5 irq gated by mask", maskedIrq, 0);
    irqMask = 1'b1;
    waitCycles(1);
    check(maskedIrq == 1, "R5 irq passes when enabled", maskedIrq, 1);
    // R6 clear
    @(negedge clk); statusClr = 1'b1;
    @(negedge clk); statusClr = 1'b0;
    check(rawFlag == 0, "R6 clear", rawFlag, 0);
    check(maskedIrq == 0, "R6 irq follows clear", maskedIrq, 0);
    // R4: still low, no second request
    waitCycles(150);
    check(rawFlag == 0, "R4 no re-request while low", rawFlag, 0);
    sclHigh();

    // R7: brief high restarts the count
    lowStart(e);
    expQ.delete();
    waitCycles(30);
    sclHigh();
    lowStart(e);
    waitCycles(60);
    check(expQ.size() == 0, "R7 restart after high", expQ.size(), 0);
    sclHigh();

    // R8: idle gap stops and clears the count
    lowStart(e);
    expQ.delete();
    waitCycles(30);
    @(negedge clk); busBusy = 1'b0;
    waitCycles(100);
    check(rawFlag == 1, "R8 no abort while idle (raw from R7)", rawFlag, 1);
    @(negedge clk); statusClr = 1'b1;
    @(negedge clk); statusClr = 1'b0;
    waitCycles(100);
    check(rawFlag == 0, "R8 idle keeps quiet", rawFlag, 0);
    @(negedge clk); busBusy = 1'b1;
    expQ.push_back(cyc + curLimit * 16 + 1);
    waitCycles(60);
    check(expQ.size() == 0, "R8 count from zero after idle", expQ.size(), 0);
    sclHigh();

    // R9: limit write mid-low restarts the count with new limit
    lowStart(e);
    expQ.delete();
    waitCycles(20);
    @(negedge clk);
    limitWrEn = 1'b1; limitWrData = 8'd2;
    e = cyc;
    @(negedge clk);
    limitWrEn = 1'b0; curLimit = 2;
    expQ.push_back(e + 1 + 32 + 1);
    waitCycles(50);
    check(expQ.size() == 0, "R9 restart on write", expQ.size(), 0);
    sclHigh();

    // R6: clear on the timeout edge, set wins
    @(negedge clk); statusClr = 1'b1;
    @(negedge clk); statusClr = 1'b0;
    lowStart(e);
    while (cyc < e - 1) @(negedge clk);
    statusClr = 1'b1;
    @(negedge clk); statusClr = 1'b0;
    check(rawFlag == 1, "R6 set wins over clear", rawFlag, 1);
    waitCycles(5);
    sclHigh();

    // R10: reserved limit 1 -> 16-clock window
    writeLimit(1);
    lowStart(e);
    check(e - cyc == 17, "R10 window length", e - cyc, 17);
    waitCycles(25);
    check(expQ.size() == 0, "R10 early abort seen", expQ.size(), 0);
    sclHigh();

    // R2: back to zero disables again
    writeLimit(0);
    lowStart(e);
    waitCycles(300);
    check(expQ.size() == 0, "R2 disabled after write 0", expQ.size(), 0);
    sclHigh();
    busBusy = 1'b0;
    waitCycles(5);
    finishRun();
  end
endmodule